// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Master and Slave Modes

This block moves eight-bit bytes over a three-wire serial link: a transfer clock, a data output and a data input. It drives the transfer clock itself as a master or follows a clock from outside as a slave. A one-byte holding register feeds a transmit shifter, and a receive shifter feeds a one-byte receive holding register. Every frame sends and receives at the same time, most significant bit first.

Software-style strobes load the transmit holding register and release the receive holding register. Level inputs select the mode, the clock idle level and phase, the prescaler and the eight-bit divisor, and the timing of the transmit interrupt. A frame only begins when transmission is enabled and a byte is waiting. Reception also requires its own enable, so a slave that wants to receive must always have a byte queued to send back. Target selection is done outside the block.

Top module: `sync_serial_port`

## Requirements
- R1: After reset `tx_empty` is 1, `rx_full`, `overrun`, `tx_irq` and `rx_irq` are 0, and `sclk_out` equals `cpol`.
- R2: In master mode each half period of `sclk_out` lasts P·(`divisor`+1) clock cycles, with P = 1, 2, 8, 32 for `presc_sel` = 0, 1, 2, 3.
- R3: A frame has exactly 16 transfer-clock edges and carries 8 bits on `sdo`, most significant bit first. `sclk_out` rests at `cpol` outside frames.
- R4: Data is sampled on the rising clock edge when `cpol` equals `cpha`, and on the falling edge otherwise. `sdo` changes only on the other edge.
- R5: A frame starts only while `tx_en` is 1 and the holding register is full (`tx_empty` = 0). Otherwise `sclk_out` stays idle and the byte stays queued.
- R6: When `rx_en` was 1 at the start of a frame, the received byte appears on `rd_data` at frame end. `rx_full` is then set and `rx_irq` pulses for one cycle. With `rx_en` = 0, `rx_full` and `rx_irq` stay 0.
- R7: With `irq_sel` = 0, `tx_irq` pulses when the byte moves into the shifter, before the first clock edge. With `irq_sel` = 1, it pulses on the last edge of the frame.
- R8: If `rx_full` is still set when the 7th bit of a new frame is sampled, `overrun` rises on that sample and that frame raises no `rx_irq`. A `rd_stb` clears both `rx_full` and `overrun`.
- R9: In slave mode (`master` = 0), bits move on the edges of `ext_clk`. A queued byte is loaded only while `ext_clk` rests at the level given by `cpol`.
- R10: A byte written during a frame leaves that frame unchanged, sets `tx_empty` to 0, and is sent in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master | input | 1 | 1: internal clock generator, 0: follow `ext_clk` |
| cpol | input | 1 | Idle level of the transfer clock |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| presc_sel | input | 2 | Prescaler select (1, 2, 8, 32) |
| divisor | input | 8 | Divisor n for the master half period |
| irq_sel | input | 1 | Transmit interrupt timing |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| wr_stb | input | 1 | Write `wr_data` into the transmit holding register |
| wr_data | input | 8 | Byte to send |
| rd_stb | input | 1 | Release the receive holding register |
| rd_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Transmit holding register is free |
| rx_full | output | 1 | Unread byte in the receive holding register |
| overrun | output | 1 | Receive overrun flag |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rx_irq | output | 1 | Receive interrupt request pulse |
| ext_clk | input | 1 | Transfer clock in slave mode |
| sclk_out | output | 1 | Transfer clock driven in master mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong edge index or phase decode shows up within one frame. Bits on `sdo` come out shifted or doubled, and the byte on `rd_data` is rotated by one place. A bad half-period count shows up at the second clock edge as a wrong interval. A stuck holding-register flag shows as a frame that never starts, or one that starts without data, after a single write. A misplaced overrun decode shows up at the exact sample where the flag rises, on the first frame sent without a read.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [1:0]        presc_sel,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              irq_sel,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_irq,
  output logic              rx_irq,
  input  logic              ext_clk,
  output logic              sclk_out,
  output logic              sdo,
  input  logic              sdi
);
  localparam int EW   = $clog2(2 * DATA_W);
  localparam int CW   = DIV_W + 6;
  localparam logic [EW-1:0]   LAST  = EW'(2 * DATA_W - 1);
  localparam logic [EW-2:0]   OVR_B = (EW-1)'(DATA_W - 2);

  logic [DATA_W-1:0] tbuf, tsr, rsr, rbuf;
  logic [EW-1:0]     eidx;
  logic [CW-1:0]     cnt, base, half_len;
  logic              busy, tog, rx_on, ovr_frame;
  logic [2:0]        xs;
  logic [1:0]        ds;

  assign base = CW'(divisor) + CW'(1);
  always_comb
    case (presc_sel)
      2'd0:    half_len = base;
      2'd1:    half_len = base << 1;
      2'd2:    half_len = base << 3;
      default: half_len = base << 5;
    endcase

  wire ext_edge = xs[1] ^ xs[2];
  wire m_tick   = cnt == half_len - CW'(1);
  wire ev       = busy && (master ? m_tick : ext_edge);
  wire din      = master ? sdi : ds[1];
  wire samp     = ev && (eidx[0] == cpha);
  wire shft     = ev && (eidx[0] != cpha) && (eidx != '0) && (eidx != LAST);
  wire last     = ev && (eidx == LAST);
  wire start    = !busy && tx_en && !tx_empty && (master || xs[1] == cpol);
  wire ovr_hit  = samp && rx_on && rx_full && (eidx[EW-1:1] == OVR_B);
  wire [DATA_W-1:0] rsr_n = {rsr[DATA_W-2:0], din};

  assign sdo      = tsr[DATA_W-1];
  assign sclk_out = master ? (cpol ^ tog) : cpol;
  assign rd_data  = rbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbuf <= '0; tsr <= '0; rsr <= '0; rbuf <= '0;
      eidx <= '0; cnt <= '0; busy <= 1'b0; tog <= 1'b0;
      rx_on <= 1'b0; ovr_frame <= 1'b0; xs <= '0; ds <= '0;
      tx_empty <= 1'b1; rx_full <= 1'b0; overrun <= 1'b0;
      tx_irq <= 1'b0; rx_irq <= 1'b0;
    end else begin
      xs <= {xs[1:0], ext_clk};
      ds <= {ds[0], sdi};
      tx_irq <= (start && !irq_sel) || (last && irq_sel);
      rx_irq <= last && rx_on && !ovr_frame && !ovr_hit;
      if (start) begin
        tsr <= tbuf; tx_empty <= 1'b1; busy <= 1'b1;
        eidx <= '0; cnt <= '0; tog <= 1'b0;
        rx_on <= rx_en; ovr_frame <= 1'b0;
      end
      if (wr_stb) begin
        tbuf <= wr_data; tx_empty <= 1'b0;
      end
      if (busy && master) cnt <= m_tick ? '0 : cnt + CW'(1);
      if (ev) begin
        eidx <= eidx + EW'(1);
        tog  <= ~tog;
      end
      if (samp) rsr <= rsr_n;
      if (shft) tsr <= {tsr[DATA_W-2:0], 1'b0};
      if (rd_stb) begin
        rx_full <= 1'b0; overrun <= 1'b0;
      end
      if (ovr_hit) begin
        overrun <= 1'b1; ovr_frame <= 1'b1;
      end
      if (last) begin
        busy <= 1'b0;
        if (rx_on) begin
          rbuf <= samp ? rsr_n : rsr;
          rx_full <= 1'b1;
        end
      end
    end
  end

  a_r5_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tx_en) && !$past(tx_empty)));
  a_r8_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_full));
  a_r6_full_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_on));
  a_r6_rx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  a_r4_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shft) |=> $stable(sdo));
endmodule

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, cpol = 1'b0, cpha = 1'b0, irq_sel = 1'b0;
  logic tx_en = 1'b1, rx_en = 1'b1, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic [7:0] divisor = 8'd0, wr_data = 8'd0;
  logic ext_clk = 1'b0, sdi = 1'b0;
  logic [7:0] rd_data;
  logic tx_empty, rx_full, overrun, tx_irq, rx_irq, sclk_out, sdo;
  int checks = 0, errors = 0, tx_irq_cnt = 0, rx_irq_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .master(master), .cpol(cpol), .cpha(cpha),
    .presc_sel(presc_sel), .divisor(divisor), .irq_sel(irq_sel),
    .tx_en(tx_en), .rx_en(rx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .tx_empty(tx_empty),
    .rx_full(rx_full), .overrun(overrun), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .ext_clk(ext_clk), .sclk_out(sclk_out), .sdo(sdo), .sdi(sdi));

  always @(negedge clk) begin
    if (tx_irq) tx_irq_cnt++;
    if (rx_irq) rx_irq_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] ps, input logic [7:0] n);
    int p;
    p = (ps == 2'd0) ? 1 : (ps == 2'd1) ? 2 : (ps == 2'd2) ? 8 : 32;
    return p * (int'(n) + 1);
  endfunction

  task automatic setup(input bit m, input bit pol, input bit pha, input logic [1:0] ps,
                       input logic [7:0] n, input bit isel, input bit re);
    @(negedge clk);
    master = m; cpol = pol; cpha = pha; presc_sel = ps; divisor = n;
    irq_sel = isel; rx_en = re; tx_en = 1'b1; ext_clk = pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    check(!rx_full && !overrun, "R8 read clears flags", {rx_full, overrun}, 0);
  endtask

  task automatic master_frame(input logic [7:0] tx, input logic [7:0] rxb, input bit do_wr,
                              input bit exp_rx, input bit exp_ovr,
                              input bit mid_wr, input logic [7:0] mid_byte);
    int edges = 0, samples = 0, since = 0, ovr_at = 0, half;
    bit early = 0, late = 0, midirq = 0, rxirq = 0;
    logic prev;
    logic [7:0] got = 8'd0;
    half = half_of(presc_sel, divisor);
    prev = cpol;
    sdi = rxb[7];
    if (do_wr) begin
      wr_data = tx; wr_stb = 1'b1;
      @(negedge clk); wr_stb = 1'b0;
    end
    for (int t = 0; t < 20000 && edges < 16; t++) begin
      @(negedge clk);
      wr_stb = 1'b0;
      since++;
      if (sclk_out != prev) begin
        if (edges > 0) check(since == half, "R2 half period", since, half);
        since = 0;
        if ((edges % 2) == int'(cpha)) begin
          check(sclk_out == (cpol == cpha), "R4 sample edge direction", sclk_out, cpol == cpha);
          got = {got[6:0], sdo};
          samples++;
          if (samples < 8) sdi = rxb[7 - samples];
        end
        prev = sclk_out;
        edges++;
        if (mid_wr && edges == 5) begin
          wr_data = mid_byte; wr_stb = 1'b1;
        end
        if (mid_wr && edges == 7)
          check(!tx_empty, "R10 byte queued during frame", tx_empty, 0);
      end
      if (overrun && ovr_at == 0) ovr_at = samples;
      if (tx_irq) begin
        if (edges == 0) early = 1;
        else if (edges == 16) late = 1;
        else midirq = 1;
      end
      if (rx_irq) rxirq = 1;
    end
    wr_stb = 1'b0;
    check(edges == 16, "R3 edge count", edges, 16);
    check(got == tx, "R3 msb-first data", got, tx);
    check(sclk_out == cpol, "R3 clock rests idle", sclk_out, cpol);
    check(!midirq, "R10 no request mid frame", midirq, 0);
    if (irq_sel) check(late && !early, "R7 request at completion", {early, late}, 1);
    else         check(early && !late, "R7 request at load", {early, late}, 2);
    if (exp_ovr) begin
      check(ovr_at == 7, "R8 overrun at 7th sample", ovr_at, 7);
      check(!rxirq, "R8 no receive request", rxirq, 0);
    end else if (exp_rx) begin
      check(rxirq && rx_full, "R6 receive flags", {rxirq, rx_full}, 3);
      check(rd_data == rxb, "R6 received byte", rd_data, rxb);
      check(ovr_at == 0, "R8 no overrun", ovr_at, 0);
    end else begin
      check(!rxirq && !rx_full, "R6 receive disabled", {rxirq, rx_full}, 0);
    end
  endtask

  task automatic slave_frame(input logic [7:0] tx, input logic [7:0] rxb, input bit stall);
    int k = 0, rx0, tx0;
    logic [7:0] got = 8'd0;
    rx0 = rx_irq_cnt; tx0 = tx_irq_cnt;
    sdi = rxb[7];
    if (stall) ext_clk = ~cpol;
    @(negedge clk); wr_data = tx; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    if (stall) begin
      repeat (10) @(negedge clk);
      check(!tx_empty, "R9 no load while clock off idle", tx_empty, 0);
      ext_clk = cpol;
    end
    repeat (5) @(negedge clk);
    check(tx_empty, "R9 load at idle level", tx_empty, 1);
    for (int e = 0; e < 16; e++) begin
      if ((e % 2) == int'(cpha)) begin
        got = {got[6:0], sdo};
        k++;
      end else if (k < 8) begin
        sdi = rxb[7 - k];
      end
      ext_clk = ~ext_clk;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(got == tx, "R9 slave transmit", got, tx);
    check(rx_full && rd_data == rxb, "R9 slave receive", rd_data, rxb);
    check(rx_irq_cnt - rx0 == 1, "R6 one receive request", rx_irq_cnt - rx0, 1);
    check(tx_irq_cnt - tx0 == 1, "R7 one transmit request", tx_irq_cnt - tx0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_empty && !rx_full && !overrun && !tx_irq && !rx_irq && sclk_out == cpol,
          "R1 reset state", {tx_empty, rx_full, overrun, tx_irq, rx_irq}, 16);

    setup(1, 0, 0, 2'd0, 8'd0, 0, 1);
    master_frame(8'hA5, 8'h3C, 1, 1, 0, 0, 8'd0);
    do_read();
    setup(1, 1, 1, 2'd1, 8'd2, 1, 1);
    master_frame(8'h81, 8'h7E, 1, 1, 0, 0, 8'd0);
    do_read();
    setup(1, 0, 0, 2'd0, 8'd255, 0, 1);
    master_frame(8'h01, 8'h80, 1, 1, 0, 0, 8'd0);
    do_read();
    setup(1, 1, 0, 2'd3, 8'd1, 1, 1);
    master_frame(8'hFF, 8'h00, 1, 1, 0, 0, 8'd0);

    // R8: second frame without a read
    master_frame(8'h5A, 8'hC3, 1, 1, 1, 0, 8'd0);
    check(overrun && rx_full, "R8 overrun flag held", {overrun, rx_full}, 3);
    do_read();

    // R5: transmit disabled keeps the byte queued
    setup(1, 1, 0, 2'd0, 8'd1, 0, 1);
    @(negedge clk); tx_en = 1'b0; wr_data = 8'h96; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sclk_out != cpol) begin
        check(0, "R5 clock idle while disabled", sclk_out, cpol);
        break;
      end
    end
    check(!tx_empty, "R5 byte stays queued", tx_empty, 0);
    tx_en = 1'b1;
    master_frame(8'h96, 8'h69, 0, 1, 0, 0, 8'd0);
    do_read();

    // R6: receive disabled, R10: write during a frame
    setup(1, 0, 1, 2'd0, 8'd1, 0, 0);
    master_frame(8'h3E, 8'hFF, 1, 0, 0, 1, 8'hC7);
    master_frame(8'hC7, 8'h11, 0, 0, 0, 0, 8'd0);

    for (int it = 0; it < 24; it++) begin
      a = 8'($urandom); b = 8'($urandom);
      setup(1, 1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom % 4),
            1'($urandom), 1);
      master_frame(a, b, 1, 1, 0, 0, 8'd0);
      do_read();
    end

    setup(0, 0, 0, 2'd0, 8'd0, 1, 1);
    slave_frame(8'hB4, 8'h2D, 1);
    do_read();
    setup(0, 1, 1, 2'd0, 8'd0, 0, 1);
    slave_frame(8'h0F, 8'hF0, 1);
    do_read();
    for (int it = 0; it < 4; it++) begin
      a = 8'($urandom); b = 8'($urandom);
      setup(0, 1'($urandom), 1'($urandom), 2'd0, 8'd0, 1'($urandom), 1);
      slave_frame(a, b, 0);
      do_read();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule